// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which pending event the processor should service next and turns that decision into a 16-bit vector address. The address is `0xFFC0 + 2 × level`. It tracks three classes of event. At the top sit reset causes at level 31. Below them are the non-maskable sources, which share level 30. Under those are a bank of maskable sources on fixed levels from 29 down to 18. Levels 14 to 0 are never handed out.

Peripheral events arrive as one-cycle set pulses into flag registers inside the block. Software clears a flag with a clear pulse, and the processor accepts a request with an acknowledge. On acknowledge, a level fed by a single source has its flag cleared automatically. A level shared by several sources keeps its flag until software clears it.

The block watches instruction fetch addresses and raises a reset request when a fetch lands in the peripheral register space. It also inspects the word read from the reset vector during boot. If that word is the erased pattern, the block asks for the deepest sleep mode instead of a jump.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector equals 0xFFC0 + 2 × level. Maskable input bit i sits at level 29 − i. Every non-maskable source sits at level 30 (0xFFFC), and the reset request uses level 31 (0xFFFE). When neither a request nor a reset is active, the vector reads 0x0000.
- R2: Among qualified pending sources, the highest level wins. Any qualified non-maskable source beats every maskable source.
- R3: A maskable source qualifies only when its flag, its own enable bit and the global enable `gie` are all 1.
- R4: A non-maskable source qualifies when its flag and its own enable are both 1, whatever the value of `gie`.
- R5: A set pulse raises a flag that holds until a software clear pulse. If set and clear arrive in the same cycle, set wins. `irq_req` rises on the second rising edge after the set pulse is driven.
- R6: An acknowledge while `irq_req` is high clears the flag of the acknowledged level only if that level is single-source. The shared maskable levels are bits 1, 5, 6, 7, 10 and 11 (levels 28, 24, 23, 22, 19, 18), and they keep their flags. The next winner, or idle, appears on the acknowledge edge itself. A set pulse in the acknowledge cycle keeps the flag, so the request returns one edge later.
- R7: While `irq_req` is high and `ack` is low, `irq_req` and `irq_vector` hold even if a higher level becomes pending.
- R8: `reset_req` is high for the edge after any of these causes: power-up, the reset pin, watchdog expiry, a key violation, or a valid fetch at an address up to and including 0x01FF. A fetch at 0x0200 or above, or a fetch without its valid bit, causes no reset. While `reset_req` is high, `irq_vector` is 0xFFFE and `irq_req` is 0, which overrides R7.
- R9: `deep_sleep` is set on the edge after a valid boot word of 0xFFFF. It is cleared by any other valid boot word or by any reset cause. A reset cause in the same cycle as the boot word wins.
- R10: `irq_req` is never high with a vector below 0xFFDE, so levels 14 to 0 are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_evt | input | 1 | Power-up reset cause |
| pin_rst | input | 1 | External reset pin cause |
| wdt_exp | input | 1 | Watchdog expiry cause |
| key_viol | input | 1 | Flash key violation cause |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Instruction fetch address |
| nmi_set | input | 3 | Non-maskable flag set pulses |
| nmi_clr | input | 3 | Non-maskable flag software clears |
| nmi_en | input | 3 | Non-maskable individual enables |
| mask_set | input | 12 | Maskable flag set pulses |
| mask_clr | input | 12 | Maskable flag software clears |
| mask_en | input | 12 | Maskable individual enables |
| gie | input | 1 | Global enable for maskable sources |
| ack | input | 1 | Processor acknowledge |
| boot_valid | input | 1 | Reset-vector word strobe |
| boot_word | input | 16 | Word read from the reset vector |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 16 | Registered vector address |
| reset_req | output | 1 | Reset request |
| deep_sleep | output | 1 | Request for the deepest sleep mode |

## Verification
Two events can land on the same edge: an acknowledge that auto-clears a single-source flag, and a new set pulse for that same source. The bench drives both in one cycle. It then expects `irq_req` to drop on that edge and to come back with the same vector one edge later. A second collision has a reset cause arrive while a request is locked awaiting acknowledge. There the bench expects the reset vector and a dropped request on the very next edge. All remaining cases are compared against vectors the bench computes from the level arithmetic. Those cases include every ordered pair of maskable sources, each non-maskable source, and the fetch-address boundary at 0x01FF/0x0200.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int LVL_W = 5;
  localparam logic [15:0] VEC_BASE = 16'hFFC0;

  function automatic logic [15:0] lvl_vec(input logic [LVL_W-1:0] lvl);
    return VEC_BASE + {10'd0, lvl, 1'b0};
  endfunction

  function automatic logic [LVL_W-1:0] vec_lvl(input logic [15:0] v);
    return v[LVL_W:1];
  endfunction
endpackage

// File: rtl/irqv_flags.sv
module irqv_flags #(
  parameter int N = 4,
  parameter logic [N-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ack_hit,
  output logic [N-1:0] q
);
  logic [N-1:0] auto_clr;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (KEEP[i]) begin : g_keep
      assign auto_clr[i] = 1'b0;
    end else begin : g_auto
      assign auto_clr[i] = ack_hit[i];
      // R6
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_hit[i] && !set[i]) |-> !q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~(sw_clr | auto_clr)) | set;
  end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_rstmon.sv
module irqv_rstmon #(
  parameter logic [15:0] PERIPH_TOP = 16'h01FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_evt,
  input  logic        pin_rst,
  input  logic        wdt_exp,
  input  logic        key_viol,
  input  logic        fetch_valid,
  input  logic [15:0] fetch_addr,
  input  logic        boot_valid,
  input  logic [15:0] boot_word,
  output logic        hit,
  output logic        reset_req,
  output logic        deep_sleep
);
  logic bad_fetch;
  logic blank_word;

  assign bad_fetch  = fetch_valid && (fetch_addr <= PERIPH_TOP);
  assign blank_word = (boot_word == 16'hFFFF);
  assign hit        = por_evt | pin_rst | wdt_exp | key_viol | bad_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req  <= 1'b0;
      deep_sleep <= 1'b0;
    end else begin
      reset_req <= hit;
      if (hit)             deep_sleep <= 1'b0;
      else if (boot_valid) deep_sleep <= blank_word;
    end
  end

  // R8
  fetch_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fetch_valid && fetch_addr <= PERIPH_TOP) |-> reset_req);

  // R9
  blank_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boot_valid && boot_word == 16'hFFFF && !hit) |-> deep_sleep);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int          N_MASK       = 12,
  parameter int          TOP_MASK_LVL = 29,
  parameter logic [11:0] MASK_SHARED  = 12'hCE2,
  parameter int          N_NMI        = 3,
  parameter int          NMI_LVL      = 30,
  parameter int          RST_LVL      = 31,
  parameter logic [15:0] PERIPH_TOP   = 16'h01FF,
  parameter int          MIN_USED_LVL = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              pin_rst,
  input  logic              wdt_exp,
  input  logic              key_viol,
  input  logic              fetch_valid,
  input  logic [15:0]       fetch_addr,
  input  logic [N_NMI-1:0]  nmi_set,
  input  logic [N_NMI-1:0]  nmi_clr,
  input  logic [N_NMI-1:0]  nmi_en,
  input  logic [N_MASK-1:0] mask_set,
  input  logic [N_MASK-1:0] mask_clr,
  input  logic [N_MASK-1:0] mask_en,
  input  logic              gie,
  input  logic              ack,
  input  logic              boot_valid,
  input  logic [15:0]       boot_word,
  output logic              irq_req,
  output logic [15:0]       irq_vector,
  output logic              reset_req,
  output logic              deep_sleep
);
  localparam int MIW = (N_MASK > 1) ? $clog2(N_MASK) : 1;
  localparam logic [LVL_W-1:0] NMI_L = LVL_W'(NMI_LVL);
  localparam logic [LVL_W-1:0] RST_L = LVL_W'(RST_LVL);
  localparam logic [LVL_W-1:0] TOP_L = LVL_W'(TOP_MASK_LVL);

  logic [N_MASK-1:0] mask_q, mask_ack_hit, mask_pend;
  logic [N_NMI-1:0]  nmi_q, nmi_pend;
  logic              m_any, n_any, win_any, rst_hit, ack_take;
  logic [MIW-1:0]    m_idx;
  logic [LVL_W-1:0]  win_lvl, ack_lvl;
  logic              irq_req_q;
  logic [15:0]       vec_q;

  assign ack_take = ack && irq_req_q;
  assign ack_lvl  = vec_lvl(vec_q);

  for (genvar i = 0; i < N_MASK; i++) begin : g_ackmap
    assign mask_ack_hit[i] = ack_take && (ack_lvl == TOP_L - LVL_W'(i));
  end

  irqv_flags #(.N(N_MASK), .KEEP(MASK_SHARED[N_MASK-1:0])) u_mask_flags (
    .clk(clk), .rst_n(rst_n), .set(mask_set), .sw_clr(mask_clr),
    .ack_hit(mask_ack_hit), .q(mask_q));

  irqv_flags #(.N(N_NMI), .KEEP({N_NMI{1'b1}})) u_nmi_flags (
    .clk(clk), .rst_n(rst_n), .set(nmi_set), .sw_clr(nmi_clr),
    .ack_hit({N_NMI{1'b0}}), .q(nmi_q));

  // Pending view excludes a flag that this edge's acknowledge is clearing.
  assign mask_pend = mask_q & ~(mask_ack_hit & ~MASK_SHARED[N_MASK-1:0])
                   & mask_en & {N_MASK{gie}};
  assign nmi_pend  = nmi_q & nmi_en;
  assign n_any     = |nmi_pend;

  irqv_prio #(.N(N_MASK), .IW(MIW)) u_prio (
    .pend(mask_pend), .any(m_any), .idx(m_idx));

  assign win_any = n_any | m_any;
  assign win_lvl = n_any ? NMI_L : (TOP_L - LVL_W'(m_idx));

  irqv_rstmon #(.PERIPH_TOP(PERIPH_TOP)) u_rstmon (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pin_rst(pin_rst),
    .wdt_exp(wdt_exp), .key_viol(key_viol), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .boot_valid(boot_valid), .boot_word(boot_word),
    .hit(rst_hit), .reset_req(reset_req), .deep_sleep(deep_sleep));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req_q <= 1'b0;
      vec_q     <= 16'h0000;
    end else if (rst_hit) begin
      irq_req_q <= 1'b0;
      vec_q     <= lvl_vec(RST_L);
    end else if (irq_req_q && !ack) begin
      irq_req_q <= irq_req_q;
      vec_q     <= vec_q;
    end else if (win_any) begin
      irq_req_q <= 1'b1;
      vec_q     <= lvl_vec(win_lvl);
    end else begin
      irq_req_q <= 1'b0;
      vec_q     <= 16'h0000;
    end
  end

  assign irq_req    = irq_req_q;
  assign irq_vector = vec_q;

  // R7
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_q && !ack && !rst_hit) |=> (irq_req_q && $stable(vec_q)));

  // R10
  unused_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_q |-> (vec_q >= lvl_vec(LVL_W'(MIN_USED_LVL)) && !vec_q[0]));

  // R3
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req_q) && vec_q < lvl_vec(NMI_L)) |-> $past(gie));

  // R8
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!irq_req_q && vec_q == lvl_vec(RST_L)));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 0, pin_rst = 0, wdt_exp = 0, key_viol = 0;
  logic fetch_valid = 0;
  logic [15:0] fetch_addr = 16'h0;
  logic [2:0] nmi_set = 0, nmi_clr = 0, nmi_en = 3'b111;
  logic [N-1:0] mask_set = 0, mask_clr = 0, mask_en = '1;
  logic gie = 1'b1, ack = 1'b0, boot_valid = 1'b0;
  logic [15:0] boot_word = 16'h0;
  logic irq_req, reset_req, deep_sleep;
  logic [15:0] irq_vector;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pin_rst(pin_rst),
    .wdt_exp(wdt_exp), .key_viol(key_viol), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .nmi_set(nmi_set), .nmi_clr(nmi_clr),
    .nmi_en(nmi_en), .mask_set(mask_set), .mask_clr(mask_clr),
    .mask_en(mask_en), .gie(gie), .ack(ack), .boot_valid(boot_valid),
    .boot_word(boot_word), .irq_req(irq_req), .irq_vector(irq_vector),
    .reset_req(reset_req), .deep_sleep(deep_sleep));

  // Vector counted down from the top slot: 0xFFFE minus two per level below 31.
  function automatic logic [15:0] exp_vec(input int lvl);
    return 16'hFFFE - 16'(2 * (31 - lvl));
  endfunction

  function automatic bit shared_lvl(input int lvl);
    return lvl == 28 || lvl == 24 || lvl == 23 || lvl == 22 || lvl == 19 || lvl == 18;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_mask(input logic [N-1:0] m);
    mask_set = m; step(); mask_set = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic clean();
    mask_clr = '1; nmi_clr = '1; pin_rst = 1'b1; step();
    mask_clr = '0; nmi_clr = '0; pin_rst = 1'b0; step();
  endtask

  task automatic fetch_try(input logic [15:0] a, input logic exp_rst);
    fetch_valid = 1'b1; fetch_addr = a; step(); fetch_valid = 1'b0;
    check("R8 fetch reset", reset_req, exp_rst);
    if (exp_rst) check("R8 reset vector", irq_vector, 16'hFFFE);
    step();
    check("R8 reset release", reset_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 idle vector", irq_vector, 16'h0000);
    check("R1 idle request", irq_req, 0);
    check("R8 idle reset", reset_req, 0);
    check("R9 idle sleep", deep_sleep, 0);

    // R1 R5 R6: each maskable source alone, then acknowledge
    for (int i = 0; i < N; i++) begin
      pulse_mask(N'(1) << i);
      check("R5 one-edge latency", irq_req, 0);
      step();
      check("R5 request", irq_req, 1);
      check("R1 vector", irq_vector, exp_vec(29 - i));
      do_ack();
      check("R6 after ack request", irq_req, shared_lvl(29 - i));
      if (shared_lvl(29 - i)) check("R6 shared vector kept", irq_vector, exp_vec(29 - i));
      else check("R6 single idle vector", irq_vector, 16'h0000);
      clean();
    end

    // R2: every pair of maskable sources
    for (int a = 0; a < N - 1; a++) begin
      for (int b = a + 1; b < N; b++) begin
        pulse_mask((N'(1) << a) | (N'(1) << b));
        step();
        check("R2 pair winner", irq_vector, exp_vec(29 - a));
        clean();
      end
    end

    // R3: global enable and individual enable gating
    gie = 1'b0;
    pulse_mask(N'(1) << 3); step(); step();
    check("R3 gie off", irq_req, 0);
    gie = 1'b1; step();
    check("R3 gie on request", irq_req, 1);
    check("R3 gie on vector", irq_vector, exp_vec(26));
    clean();
    mask_en = ~(N'(1) << 3);
    pulse_mask(N'(1) << 3); step(); step();
    check("R3 enable off", irq_req, 0);
    mask_en = '1;
    clean();

    // R4: non-maskable sources ignore gie
    gie = 1'b0;
    for (int k = 0; k < 3; k++) begin
      nmi_set = 3'(1 << k); step(); nmi_set = '0; step();
      check("R4 nmi request", irq_req, 1);
      check("R4 nmi vector", irq_vector, 16'hFFFC);
      clean();
    end
    nmi_en = 3'b000;
    nmi_set = 3'b111; step(); nmi_set = '0; step(); step();
    check("R4 nmi enable off", irq_req, 0);
    nmi_en = 3'b111;
    clean();
    gie = 1'b1;

    // R2: non-maskable beats top maskable
    nmi_set = 3'b001; mask_set = N'(1); step(); nmi_set = '0; mask_set = '0; step();
    check("R2 nmi over maskable", irq_vector, 16'hFFFC);
    clean();

    // R5: set wins over software clear in the same cycle
    mask_set = N'(1) << 4; mask_clr = N'(1) << 4; step();
    mask_set = '0; mask_clr = '0; step();
    check("R5 set beats clear", irq_vector, exp_vec(25));
    clean();

    // R7: lock until acknowledge, then R6 next winner at the ack edge
    pulse_mask(N'(1) << 7); step();
    check("R7 first vector", irq_vector, exp_vec(22));
    pulse_mask(N'(1)); step(); step();
    check("R7 held vector", irq_vector, exp_vec(22));
    do_ack();
    check("R6 next winner", irq_vector, exp_vec(29));
    do_ack();
    check("R6 shared remains", irq_vector, exp_vec(22));
    clean();

    // R6: acknowledge and a new set pulse in one cycle
    pulse_mask(N'(1)); step();
    check("R6 pre-collision", irq_vector, exp_vec(29));
    ack = 1'b1; mask_set = N'(1); step(); ack = 1'b0; mask_set = '0;
    check("R6 collision drop", irq_req, 0);
    step();
    check("R6 collision return req", irq_req, 1);
    check("R6 collision return vec", irq_vector, exp_vec(29));
    clean();

    // R8: fetch boundary and every cause
    fetch_try(16'h0000, 1'b1);
    fetch_try(16'h0100, 1'b1);
    fetch_try(16'h01FF, 1'b1);
    fetch_try(16'h0200, 1'b0);
    fetch_try(16'h8000, 1'b0);
    fetch_try(16'hFFFE, 1'b0);
    fetch_addr = 16'h0000; step();
    check("R8 no strobe no reset", reset_req, 0);
    por_evt = 1; step(); por_evt = 0; check("R8 power-up", reset_req, 1); step();
    pin_rst = 1; step(); pin_rst = 0; check("R8 pin", reset_req, 1); step();
    wdt_exp = 1; step(); wdt_exp = 0; check("R8 watchdog", reset_req, 1); step();
    key_viol = 1; step(); key_viol = 0; check("R8 key", reset_req, 1); step();
    pulse_mask(N'(1) << 2); step();
    check("R8 pre-override", irq_req, 1);
    wdt_exp = 1; step(); wdt_exp = 0;
    check("R8 override request", irq_req, 0);
    check("R8 override vector", irq_vector, 16'hFFFE);
    clean();

    // R9: blank reset vector
    boot_valid = 1; boot_word = 16'hFFFF; step(); boot_valid = 0;
    check("R9 blank sleeps", deep_sleep, 1);
    boot_valid = 1; boot_word = 16'hC000; step(); boot_valid = 0;
    check("R9 programmed wakes", deep_sleep, 0);
    boot_valid = 1; boot_word = 16'hFFFF; step(); boot_valid = 0;
    pin_rst = 1; step(); pin_rst = 0;
    check("R9 reset clears", deep_sleep, 0);
    boot_valid = 1; boot_word = 16'hFFFF; key_viol = 1; step();
    boot_valid = 0; key_viol = 0;
    check("R9 reset wins", deep_sleep, 0);
    boot_valid = 1; boot_word = 16'hFFFE; step(); boot_valid = 0;
    check("R9 near-blank", deep_sleep, 0);
    step();

    // R10: lowest maskable level still above the unused range
    pulse_mask(N'(1) << (N - 1)); step();
    check("R10 lowest used", (irq_vector >= 16'hFFDE) ? 1 : 0, 1);
    clean();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule